// File: doc/BRIEF.md
# Dual-Trigger Conversion Sequencer for an A/D Converter

This block holds the control and status logic for an analog-to-digital converter that can be started two ways: by a processor write, or by a hardware or external trigger event. A processor reaches it through an 8-bit register port with read and write strobes. The block issues a one-cycle start request to the converter and tags it with the source that caused it. When the converter returns a done pulse and a data word, the block stores the word in the result register that belongs to that source.

Each source has its own end-of-conversion flag. Clearing a flag takes two steps: the processor must first read the flag as 1 and then write 0 to it, so an end event that arrives between the read and the write is not lost. A request that arrives while a conversion is running is held and serviced when that conversion finishes. When both sources ask in the same cycle, the hardware source goes first. An interrupt output combines the two flags with an enable bit.

Top module: `adc_dual_seq`

## Requirements
- R1: Writing the status register (address 0) with bit 4 set requests a software conversion. Bit 4 reads 1 from the cycle after that write until the cycle after the conversion's done pulse, and 0 after that.
- R2: Each clock cycle with `hw_trig_i` high requests a hardware conversion. Bit 3 reads 1 from the cycle after the trigger until the cycle after that conversion's done pulse.
- R3: When a software request and a hardware request arrive in the same cycle, the next start is the hardware one (`conv_src_o` = 1). The software request is kept and started after the hardware conversion finishes (`conv_src_o` = 0).
- R4: A software conversion's data is readable at address 1 and a hardware conversion's data at address 2. A conversion does not change the other source's result register.
- R5: Bit 7 becomes 1 when a software conversion ends. Bit 6 becomes 1 when a hardware conversion ends.
- R6: Writing 0 to bit 7 or bit 6 clears that flag only if a read strobe at address 0 saw the flag as 1 after it was last set. Writing 0 without such a read leaves the flag at 1. Writing 1 has no effect.
- R7: Bit 2 (busy) reads 1 in the cycle `conv_start_o` is high and stays at 1 until the done pulse is taken. While the block is busy, `conv_start_o` stays low. A request made while busy is started after the current conversion finishes.
- R8: After reset, and in the cycle after any cycle with `stop_i` high, address 0 reads 0x01 and `irq_o` is 0.
- R9: `irq_o` is 1 exactly when bit 5 (interrupt enable) is 1 and bit 7 or bit 6 is 1.
- R10: If a flag is set by a finishing conversion in the same cycle as a valid clearing write, the flag stays at 1. A fresh read is then needed before it can be cleared.
- R11: Bit 1 is a plain read/write storage bit. Bit 0 always reads 1. Writes to bits 3, 2 and 0 have no effect and start no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Low-power or module-stop request; synchronously returns control state to its reset value |
| csr_wr_i | input | 1 | Register write strobe |
| csr_rd_i | input | 1 | Register read strobe (arms flag clearing) |
| csr_addr_i | input | 2 | Register address: 0 status/control, 1 software result, 2 hardware result |
| csr_wdata_i | input | 8 | Write data |
| csr_rdata_o | output | 8 | Read data for the addressed register |
| hw_trig_i | input | 1 | Hardware or external trigger event |
| conv_start_o | output | 1 | One-cycle start request to the converter |
| conv_src_o | output | 1 | Source of the current conversion: 1 hardware, 0 software |
| conv_done_i | input | 1 | Conversion finished pulse from the converter |
| conv_data_i | input | DATA_W | Converted data word, valid with `conv_done_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The sequencer is driven with four start patterns. A lone software start and a lone hardware start show that each source uses its own busy/start bit, result register and flag. Simultaneous software and hardware requests show the hardware-first order. A hardware trigger that arrives during a running software conversion shows that a request made while busy is held rather than dropped or started early. A scoreboard records the expected order of conversion sources and compares it with every `conv_start_o` pulse. The flag checks use clearing writes with and without a prior read, a write of ones, and a clearing write timed to coincide with the done pulse, which tells a correct two-step clear apart from a plain write-0-to-clear.

// File: rtl/adc_dual_seq_pkg.sv
package adc_dual_seq_pkg;

    typedef enum logic {
        SRC_SW = 1'b0,
        SRC_HW = 1'b1
    } src_e;

    localparam int NUM_SRC = 2;
    localparam int CSR_W   = 8;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADR_CSR   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_SWRES = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_HWRES = 2'd2;

    // status/control bit positions
    localparam int BIT_SWDONE = 7;
    localparam int BIT_HWDONE = 6;
    localparam int BIT_IRQEN  = 5;
    localparam int BIT_SWGO   = 4;
    localparam int BIT_HWGO   = 3;
    localparam int BIT_BUSY   = 2;
    localparam int BIT_SPARE  = 1;
    localparam int BIT_ONE    = 0;

    typedef struct packed {
        logic sw_pend;
        logic hw_pend;
        logic busy;
        src_e src;
        logic start;
    } arb_st_t;

    typedef struct packed {
        logic flag;
        logic armed;
    } flg_st_t;

    typedef struct packed {
        logic irq_en;
        logic spare;
    } ctl_st_t;

    // done-flag bit for each source index
    function automatic int done_bit(input int idx);
        return (idx == int'(SRC_SW)) ? BIT_SWDONE : BIT_HWDONE;
    endfunction

endpackage

// File: rtl/adc_trig_arb.sv
module adc_trig_arb
    import adc_dual_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic sw_req_i,
    input  logic hw_req_i,
    input  logic done_i,
    output logic start_o,
    output src_e src_o,
    output logic busy_o,
    output logic sw_go_o,
    output logic hw_go_o,
    output logic fin_o,
    output src_e fin_src_o
);

    arb_st_t q, d;
    logic    fin;
    logic    launch;
    logic    take_hw;
    logic    take_sw;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        fin     = q.busy & done_i;
        launch  = ~q.busy & (q.hw_pend | q.sw_pend);
        take_hw = launch & q.hw_pend;
        take_sw = launch & ~q.hw_pend;

        if (fin) begin
            d.busy = 1'b0;
        end
        if (launch) begin
            d.busy  = 1'b1;
            d.start = 1'b1;
            d.src   = take_hw ? SRC_HW : SRC_SW;
        end
        d.hw_pend = (q.hw_pend & ~take_hw) | hw_req_i;
        d.sw_pend = (q.sw_pend & ~take_sw) | sw_req_i;

        if (flush_i) begin
            d = '{sw_pend: 1'b0, hw_pend: 1'b0, busy: 1'b0, src: SRC_SW, start: 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sw_pend: 1'b0, hw_pend: 1'b0, busy: 1'b0, src: SRC_SW, start: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign start_o   = q.start;
    assign src_o     = q.src;
    assign busy_o    = q.busy;
    assign sw_go_o   = q.sw_pend | (q.busy & (q.src == SRC_SW));
    assign hw_go_o   = q.hw_pend | (q.busy & (q.src == SRC_HW));
    assign fin_o     = fin;
    assign fin_src_o = q.src;

    AST_HW_FIRST: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
        (!q.busy && q.hw_pend) |=> (q.start && q.src == SRC_HW)); // R3

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
        (q.busy && !done_i) |=> !q.start); // R7

    AST_SW_GO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
        (sw_go_o && !fin) |=> sw_go_o); // R1

endmodule

// File: rtl/adc_end_flag.sv
module adc_end_flag
    import adc_dual_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic set_i,
    input  logic rd_hit_i,
    input  logic clr_wr_i,
    output logic flag_o
);

    flg_st_t q, d;
    logic    clr;

    always_comb begin
        d   = q;
        clr = clr_wr_i & q.armed & q.flag;

        d.flag = (q.flag & ~clr) | set_i;

        if (set_i) begin
            d.armed = 1'b0;
        end else if (clr) begin
            d.armed = 1'b0;
        end else if (rd_hit_i && q.flag) begin
            d.armed = 1'b1;
        end

        if (flush_i) begin
            d = '{flag: 1'b0, armed: 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{flag: 1'b0, armed: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign flag_o = q.flag;

    AST_NO_CLEAR_UNREAD: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
        (q.flag && !q.armed) |=> q.flag); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
        set_i |=> q.flag); // R10

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_dual_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  src_e                            sel_i,
    input  logic [DATA_W-1:0]               data_i,
    output logic [NUM_SRC-1:0][DATA_W-1:0]  res_o
);

    logic [NUM_SRC-1:0][DATA_W-1:0] res_q, res_d;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        always_comb begin
            res_d[i] = res_q[i];
            if (we_i && (sel_i == src_e'(i))) begin
                res_d[i] = data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[i] <= '0;
            end else begin
                res_q[i] <= res_d[i];
            end
        end

        AST_OTHER_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && sel_i == src_e'(i)) |=> $stable(res_q[i])); // R4
    end

    assign res_o = res_q;

endmodule

// File: rtl/adc_dual_seq.sv
module adc_dual_seq
    import adc_dual_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_i,
    input  logic              csr_wr_i,
    input  logic              csr_rd_i,
    input  logic [1:0]        csr_addr_i,
    input  logic [7:0]        csr_wdata_i,
    output logic [7:0]        csr_rdata_o,
    input  logic              hw_trig_i,
    output logic              conv_start_o,
    output logic              conv_src_o,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic              irq_o
);

    localparam int RES_PAD = CSR_W - DATA_W;

    ctl_st_t q, d;

    logic                           csr_sel;
    logic                           csr_wr;
    logic                           sw_req;
    logic                           busy;
    logic                           sw_go;
    logic                           hw_go;
    logic                           fin;
    src_e                           fin_src;
    src_e                           cur_src;
    logic [NUM_SRC-1:0]             flags;
    logic [NUM_SRC-1:0][DATA_W-1:0] results;
    logic [CSR_W-1:0]               csr_view;
    logic                           unused_wbits;

    assign csr_sel = (csr_addr_i == ADR_CSR);
    assign csr_wr  = csr_wr_i & csr_sel;
    assign sw_req  = csr_wr & csr_wdata_i[BIT_SWGO];

    // writes to the read-only positions are discarded
    assign unused_wbits = ^{csr_wdata_i[BIT_HWGO], csr_wdata_i[BIT_BUSY], csr_wdata_i[BIT_ONE]};

    adc_trig_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (stop_i),
        .sw_req_i  (sw_req),
        .hw_req_i  (hw_trig_i),
        .done_i    (conv_done_i),
        .start_o   (conv_start_o),
        .src_o     (cur_src),
        .busy_o    (busy),
        .sw_go_o   (sw_go),
        .hw_go_o   (hw_go),
        .fin_o     (fin),
        .fin_src_o (fin_src)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        localparam int FBIT = done_bit(i);

        adc_end_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush_i  (stop_i),
            .set_i    (fin && (fin_src == src_e'(i))),
            .rd_hit_i (csr_rd_i && csr_sel),
            .clr_wr_i (csr_wr && !csr_wdata_i[FBIT]),
            .flag_o   (flags[i])
        );
    end

    adc_result_bank #(
        .DATA_W (DATA_W)
    ) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (fin),
        .sel_i  (fin_src),
        .data_i (conv_data_i),
        .res_o  (results)
    );

    always_comb begin
        d = q;
        if (csr_wr) begin
            d.irq_en = csr_wdata_i[BIT_IRQEN];
            d.spare  = csr_wdata_i[BIT_SPARE];
        end
        if (stop_i) begin
            d = '{irq_en: 1'b0, spare: 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{irq_en: 1'b0, spare: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        csr_view             = '0;
        csr_view[BIT_SWDONE] = flags[int'(SRC_SW)];
        csr_view[BIT_HWDONE] = flags[int'(SRC_HW)];
        csr_view[BIT_IRQEN]  = q.irq_en;
        csr_view[BIT_SWGO]   = sw_go;
        csr_view[BIT_HWGO]   = hw_go;
        csr_view[BIT_BUSY]   = busy;
        csr_view[BIT_SPARE]  = q.spare;
        csr_view[BIT_ONE]    = 1'b1;
    end

    always_comb begin
        case (csr_addr_i)
            ADR_CSR:   csr_rdata_o = csr_view;
            ADR_SWRES: csr_rdata_o = {{RES_PAD{1'b0}}, results[int'(SRC_SW)]};
            ADR_HWRES: csr_rdata_o = {{RES_PAD{1'b0}}, results[int'(SRC_HW)]};
            default:   csr_rdata_o = '0;
        endcase
    end

    assign conv_src_o = (cur_src == SRC_HW);
    assign irq_o      = q.irq_en & (|flags);

    AST_STOP_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (csr_view == 8'h01 && !irq_o)); // R8

    AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n || stop_i)
        (!busy && $past(!busy) && conv_start_o) |-> 1'b0); // R7

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (csr_view[BIT_SWDONE] || csr_view[BIT_HWDONE])); // R9

endmodule

// File: tb/sim_adc_dual_seq.sv
`timescale 1ns/1ps
module sim_adc_dual_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_i = 1'b0;
    logic       csr_wr_i = 1'b0;
    logic       csr_rd_i = 1'b0;
    logic [1:0] csr_addr_i = 2'd0;
    logic [7:0] csr_wdata_i = 8'h00;
    logic [7:0] csr_rdata_o;
    logic       hw_trig_i = 1'b0;
    logic       conv_start_o;
    logic       conv_src_o;
    logic       conv_done_i = 1'b0;
    logic [7:0] conv_data_i = 8'h00;
    logic       irq_o;

    int n_chk = 0;
    int n_err = 0;
    int stub_cnt = 0;
    int conv_n = 0;
    logic exp_src_q[$];

    always #10 clk = ~clk;

    adc_dual_seq #(.DATA_W(8)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_i       (stop_i),
        .csr_wr_i     (csr_wr_i),
        .csr_rd_i     (csr_rd_i),
        .csr_addr_i   (csr_addr_i),
        .csr_wdata_i  (csr_wdata_i),
        .csr_rdata_o  (csr_rdata_o),
        .hw_trig_i    (hw_trig_i),
        .conv_start_o (conv_start_o),
        .conv_src_o   (conv_src_o),
        .conv_done_i  (conv_done_i),
        .conv_data_i  (conv_data_i),
        .irq_o        (irq_o)
    );

    // converter stub: done three negedges after the start is seen, data 0x50 + n
    always @(negedge clk) begin
        conv_done_i = 1'b0;
        if (stub_cnt != 0) begin
            stub_cnt = stub_cnt - 1;
            if (stub_cnt == 0) begin
                conv_done_i = 1'b1;
                conv_data_i = 8'h50 + 8'(conv_n);
                conv_n      = conv_n + 1;
            end
        end
        if (conv_start_o) stub_cnt = 3;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // scoreboard driver side
    task automatic expect_src(input logic s);
        exp_src_q.push_back(s);
    endtask

    // scoreboard monitor side
    always @(negedge clk) begin
        if (rst_n && conv_start_o) begin
            n_chk++;
            if (exp_src_q.size() == 0) begin
                n_err++;
                $display("FAIL R3/R7 unexpected start act=%b exp=none", conv_src_o);
            end else begin
                logic e;
                e = exp_src_q.pop_front();
                if (conv_src_o !== e) begin
                    n_err++;
                    $display("FAIL R3 start source act=%b exp=%b", conv_src_o, e);
                end
            end
        end
    end

    task automatic csr_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        csr_wr_i = 1'b1; csr_addr_i = a; csr_wdata_i = v;
        @(negedge clk);
        csr_wr_i = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] a);
        @(negedge clk);
        csr_rd_i = 1'b1; csr_addr_i = a;
        @(negedge clk);
        csr_rd_i = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        csr_addr_i = a;
        #1 v = csr_rdata_o;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_start();
        do @(negedge clk); while (!conv_start_o);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        peek(0, v); check("R8 reset value", v, 8'h01);
        check("R8 reset irq", {7'b0, irq_o}, 8'h00);

        // lone software start
        expect_src(1'b0);
        csr_wr(0, 8'h10);
        peek(0, v); check("R1 go bit set", v & 8'h10, 8'h10);
        idle(10);
        peek(0, v); check("R1 R5 after sw end", v, 8'h81);
        peek(1, v); check("R4 sw result", v, 8'h50);
        check("R9 irq off while disabled", {7'b0, irq_o}, 8'h00);

        // clearing without prior read, and writing ones
        csr_wr(0, 8'h00);
        peek(0, v); check("R6 unread clear ignored", v, 8'h81);
        csr_wr(0, 8'hC0);
        peek(0, v); check("R6 write ones no effect", v, 8'h81);
        csr_rd(0);
        csr_wr(0, 8'h00);
        peek(0, v); check("R6 read then clear", v, 8'h01);

        // lone hardware trigger
        expect_src(1'b1);
        @(negedge clk); hw_trig_i = 1'b1;
        @(negedge clk); hw_trig_i = 1'b0;
        peek(0, v); check("R2 hw go bit set", v, 8'h09);
        idle(10);
        peek(0, v); check("R2 R5 after hw end", v, 8'h41);
        peek(2, v); check("R4 hw result", v, 8'h51);
        peek(1, v); check("R4 sw result untouched", v, 8'h50);

        // interrupt enable
        csr_wr(0, 8'h20);
        check("R9 irq on", {7'b0, irq_o}, 8'h01);
        csr_rd(0);
        csr_wr(0, 8'h20);
        peek(0, v); check("R6 hw flag cleared", v, 8'h21);
        check("R9 irq off without flags", {7'b0, irq_o}, 8'h00);

        // collision: both requests in one cycle
        expect_src(1'b1);
        expect_src(1'b0);
        @(negedge clk);
        csr_wr_i = 1'b1; csr_addr_i = 2'd0; csr_wdata_i = 8'h30; hw_trig_i = 1'b1;
        @(negedge clk);
        csr_wr_i = 1'b0; hw_trig_i = 1'b0;
        idle(20);
        peek(0, v); check("R3 both ended", v, 8'hE1);
        peek(2, v); check("R3 hw served first", v, 8'h52);
        peek(1, v); check("R3 sw served second", v, 8'h53);

        // request while busy is held
        expect_src(1'b0);
        expect_src(1'b1);
        csr_wr(0, 8'hF0);
        wait_start();
        peek(0, v); check("R7 busy at start", v & 8'h04, 8'h04);
        hw_trig_i = 1'b1;
        @(negedge clk); hw_trig_i = 1'b0;
        peek(0, v); check("R7 busy holds", v & 8'h04, 8'h04);
        idle(20);
        peek(1, v); check("R7 sw result", v, 8'h54);
        peek(2, v); check("R7 held hw result", v, 8'h55);
        peek(0, v); check("R7 idle after both", v, 8'hE1);

        // set and clear in the same cycle
        expect_src(1'b0);
        csr_wr(0, 8'hB0);
        wait_start();
        @(negedge clk); csr_rd_i = 1'b1; csr_addr_i = 2'd0;
        @(negedge clk); csr_rd_i = 1'b0;
        @(negedge clk); csr_wr_i = 1'b1; csr_wdata_i = 8'h20;
        @(negedge clk); csr_wr_i = 1'b0;
        peek(0, v); check("R10 set beats clear", v, 8'hA1);
        peek(1, v); check("R10 result stored", v, 8'h56);
        csr_wr(0, 8'h20);
        peek(0, v); check("R10 fresh read needed", v, 8'hA1);
        csr_rd(0);
        csr_wr(0, 8'h20);
        peek(0, v); check("R6 all cleared", v, 8'h21);

        // spare bit and read-only positions
        csr_wr(0, 8'h2E);
        peek(0, v); check("R11 spare stored", v, 8'h23);
        idle(8);
        peek(0, v); check("R11 no conversion started", v, 8'h23);

        // stop input
        csr_rd(0);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        peek(0, v); check("R8 stop value", v, 8'h01);
        check("R8 stop irq", {7'b0, irq_o}, 8'h00);

        n_chk++;
        if (exp_src_q.size() != 0) begin
            n_err++;
            $display("FAIL R3 pending expected starts act=%0d exp=0", exp_src_q.size());
        end
        finish_run();
    end

endmodule